// File: doc/BRIEF.md
# SD Host Single-Address DMA Boundary Engine

This block carries the data phase of an SD host controller between a byte-wide card data stream and system memory. Software loads a starting memory address, a block length with a buffer-boundary code, and a block count. A write to the transfer-mode register then starts the transfer. The mode fields select the direction, single- or multi-block operation, block counting and an automatic stop request. Each byte becomes one memory beat, and the system address register steps by one per beat.

Whenever a beat leaves the address sitting on a multiple of the programmed boundary size, the engine stops issuing memory beats and raises a DMA-boundary status flag. Software resumes the transfer by writing the system address register, normally with the value it reads back. After the final byte the engine raises a transfer-complete flag. Both flags clear only when a 1 is written to their bit.

Both data interfaces use valid/ready handshakes. A beat or byte moves on a rising edge where valid and ready are both high. A source that raises valid keeps valid high and its data unchanged until ready is seen. In the card-to-memory direction, card bytes pass straight through to the memory request port, so `card_rx_ready` follows `mem_req_ready`. In the memory-to-card direction, at most one memory read is outstanding at a time.

Top module: `sd_sdma_engine`

## Requirements
- R1: After reset, `busy`, `irq_done`, `irq_bnd` and `stop_req` are 0, `sys_addr` is 0 and no memory request or card byte is offered.
- R2: A write of transfer-mode register (select 3) starts a transfer only when all of these hold: the engine is idle; mode bit 0 (DMA enable) is set; host-control bits [4:3] (select 4) are 00, the single-address mode; the block length is non-zero; and, when bit 5 (multi-block) is set, bit 1 (count enable) is also set and the block count is non-zero. Any other mode write leaves `busy` at 0 and no request is issued.
- R3: With mode bit 4 set (card to memory), each card byte becomes a memory write beat (`mem_req_we`=1) to `sys_addr`, in arrival order, with addresses rising by one.
- R4: With mode bit 4 clear (memory to card), the engine reads memory (`mem_req_we`=0) from rising addresses with one read outstanding, and presents the returned bytes on the card port in address order.
- R5: The block length is block-size bits [11:0] (select 1) and the count is select 2 bits [15:0]. A multi-block transfer moves length × count bytes. A single-block transfer moves exactly length bytes, whatever the count register holds.
- R6: The boundary size is 4096 << code, where the code is block-size bits [14:12]. A beat that is not the last, and that leaves the next address a multiple of that size, stops further memory beats and sets `irq_bnd` (status bit 3).
- R7: `sys_addr` always shows the next address to be accessed. A write of select 0 loads it and releases a boundary pause, and the transfer continues from the loaded address.
- R8: After the last byte, `busy` falls and `irq_done` (status bit 1) rises. In the card-to-memory direction this is the last accepted memory beat; in the memory-to-card direction it is the last card handshake. A boundary hit on the last byte raises no `irq_bnd`.
- R9: A write to select 5 clears `irq_done` where data bit 1 is 1 and `irq_bnd` where data bit 3 is 1. A 0 bit leaves its flag unchanged.
- R10: `stop_req` pulses for one cycle, together with the rise of `irq_done`, only when the transfer had mode bits 2 and 5 both set.
- R11: `card_tx_valid` and `card_tx_data` hold steady while the card withholds `card_tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 address, 1 block size, 2 block count, 3 mode/start, 4 host control, 5 status clear |
| cfg_wdata | input | 32 | Register write data |
| sys_addr | output | 32 | Next memory address |
| busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | Transfer-complete flag |
| irq_bnd | output | 1 | DMA boundary flag |
| stop_req | output | 1 | Automatic stop-command request pulse |
| card_rx_valid | input | 1 | Card byte available |
| card_rx_data | input | 8 | Card byte |
| card_rx_ready | output | 1 | Engine accepts card byte |
| card_tx_valid | output | 1 | Byte for card available |
| card_tx_data | output | 8 | Byte for card |
| card_tx_ready | input | 1 | Card accepts byte |
| mem_req_valid | output | 1 | Memory beat request |
| mem_req_ready | input | 1 | Memory accepts beat |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Beat address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 8 | Read byte |
| mem_rsp_ready | output | 1 | Engine accepts read data |

## Verification
The bench starts transfers just below boundaries of several sizes. A wrong size or mask would pause at 4 KiB under code 1, or miss the 512 KiB crossing. It puts a boundary on the final byte, where a design that tests the wrap before the end would raise a stray `irq_bnd` and hang. Block and boundary edges are made to coincide in multi-block runs, and a single-block run is given a count of zero. A counter that honoured the count there would stall or move nothing. Random stalls on every handshake expose a read engine that drops or repeats a byte under back-pressure, and a resume that restarts from a stale address.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] SEL_ADDR  = 3'd0;
  localparam logic [2:0] SEL_BSIZE = 3'd1;
  localparam logic [2:0] SEL_BCNT  = 3'd2;
  localparam logic [2:0] SEL_MODE  = 3'd3;
  localparam logic [2:0] SEL_HCTL  = 3'd4;
  localparam logic [2:0] SEL_STS   = 3'd5;

  localparam int MODE_DMA   = 0;
  localparam int MODE_CNT   = 1;
  localparam int MODE_ASTOP = 2;
  localparam int MODE_RD    = 4;
  localparam int MODE_MULTI = 5;

  localparam int STS_DONE = 1;
  localparam int STS_BND  = 3;

  localparam int BND_LSB  = 12;
  localparam int HCTL_LSB = 3;

  typedef struct packed {
    logic rd;
    logic multi;
    logic astop;
  } xfer_mode_t;
endpackage

// File: rtl/sdma_cfg.sv
module sdma_cfg import sdma_pkg::*; #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16,
  parameter int BND_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic             busy,
  input  logic [LEN_W-1:0] len_in,
  input  logic [BND_W-1:0] code_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [1:0]       hctl_in,
  input  logic             m_dma,
  input  logic             m_cnt,
  input  logic             m_astop,
  input  logic             m_rd,
  input  logic             m_multi,
  output logic [LEN_W-1:0] len_q,
  output logic [BND_W-1:0] code_q,
  output logic [CNT_W-1:0] cnt_q,
  output xfer_mode_t       mode,
  output logic             start
);
  logic [1:0] hctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      code_q <= '0;
      cnt_q  <= '0;
      hctl_q <= '0;
    end else if (wr) begin
      if (sel == SEL_BSIZE) begin
        len_q  <= len_in;
        code_q <= code_in;
      end
      if (sel == SEL_BCNT) cnt_q  <= cnt_in;
      if (sel == SEL_HCTL) hctl_q <= hctl_in;
    end
  end

  logic count_ok;
  assign count_ok = !m_multi || (m_cnt && (cnt_q != '0));
  assign start = wr && (sel == SEL_MODE) && !busy && m_dma &&
                 (hctl_q == 2'b00) && (len_q != '0) && count_ok;
  assign mode  = '{rd: m_rd, multi: m_multi, astop: m_astop};
endmodule

// File: rtl/sdma_counter.sv
module sdma_counter #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic [CNT_W-1:0] nblk_in,
  input  logic             beat,
  output logic             last
);
  logic [LEN_W-1:0] len_q, byte_q;
  logic [CNT_W-1:0] nblk_q, blk_q;
  logic             blk_end;

  assign blk_end = (byte_q == len_q - LEN_W'(1));
  assign last    = blk_end && (blk_q == nblk_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      nblk_q <= '0;
      byte_q <= '0;
      blk_q  <= '0;
    end else if (start) begin
      len_q  <= len_in;
      nblk_q <= nblk_in;
      byte_q <= '0;
      blk_q  <= '0;
    end else if (beat) begin
      if (blk_end) begin
        byte_q <= '0;
        blk_q  <= blk_q + CNT_W'(1);
      end else begin
        byte_q <= byte_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
  parameter int ADDR_W     = 32,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              start,
  input  logic [BND_W-1:0]  code_in,
  input  logic              beat,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  logic [BND_W-1:0]  code_q;
  logic [ADDR_W-1:0] mask, next;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      mask[i] = (i < (BASE_SHIFT + int'(code_q)));
  end

  assign next = addr + ADDR_W'(1);
  assign wrap = ((next & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      code_q <= '0;
    end else begin
      if (start) code_q <= code_in;
      if (load)       addr <= load_val;
      else if (beat)  addr <= next;
    end
  end
endmodule

// File: rtl/sd_sdma_engine.sv
module sd_sdma_engine import sdma_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 16,
  parameter int BND_W      = 3,
  parameter int BASE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] sys_addr,
  output logic              busy,
  output logic              irq_done,
  output logic              irq_bnd,
  output logic              stop_req,
  input  logic              card_rx_valid,
  input  logic [DATA_W-1:0] card_rx_data,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [DATA_W-1:0] card_tx_data,
  input  logic              card_tx_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              mem_rsp_ready
);
  logic [LEN_W-1:0] len_q;
  logic [BND_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q, nblk;
  xfer_mode_t       mode_in, mode_q;
  logic             start, last, wrap, beat;

  sdma_cfg #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BND_W(BND_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .busy(busy),
    .len_in(cfg_wdata[LEN_W-1:0]), .code_in(cfg_wdata[BND_LSB +: BND_W]),
    .cnt_in(cfg_wdata[CNT_W-1:0]), .hctl_in(cfg_wdata[HCTL_LSB +: 2]),
    .m_dma(cfg_wdata[MODE_DMA]), .m_cnt(cfg_wdata[MODE_CNT]),
    .m_astop(cfg_wdata[MODE_ASTOP]), .m_rd(cfg_wdata[MODE_RD]),
    .m_multi(cfg_wdata[MODE_MULTI]),
    .len_q(len_q), .code_q(code_q), .cnt_q(cnt_q), .mode(mode_in),
    .start(start)
  );

  assign nblk = mode_in.multi ? cnt_q : CNT_W'(1);

  sdma_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(len_q),
    .nblk_in(nblk), .beat(beat), .last(last)
  );

  sdma_addr #(.ADDR_W(ADDR_W), .BND_W(BND_W), .BASE_SHIFT(BASE_SHIFT)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(cfg_wr && (cfg_sel == SEL_ADDR)), .load_val(cfg_wdata[ADDR_W-1:0]),
    .start(start), .code_in(code_q), .beat(beat),
    .addr(sys_addr), .wrap(wrap)
  );

  logic held_q, last_q, pend_q, have_q;
  logic [DATA_W-1:0] buf_q;
  logic go, tx_fire, rsp_fire, done_now, bnd_set, sts_clr;

  assign go       = busy && !held_q && !last_q;
  assign beat     = mem_req_valid && mem_req_ready;
  assign tx_fire  = have_q && card_tx_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;
  assign done_now = busy && (mode_q.rd ? (beat && last) : (tx_fire && last_q));
  assign bnd_set  = beat && !last && wrap;
  assign sts_clr  = cfg_wr && (cfg_sel == SEL_STS);

  assign mem_req_valid = go && (mode_q.rd ? card_rx_valid : !pend_q);
  assign mem_req_we    = mode_q.rd;
  assign mem_req_addr  = sys_addr;
  assign mem_req_wdata = card_rx_data;
  assign card_rx_ready = go && mode_q.rd && mem_req_ready;
  assign mem_rsp_ready = busy && pend_q && !have_q;
  assign card_tx_valid = have_q;
  assign card_tx_data  = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= '0;
      held_q <= 1'b0;
      last_q <= 1'b0;
      pend_q <= 1'b0;
      have_q <= 1'b0;
      buf_q  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      mode_q <= mode_in;
      held_q <= 1'b0;
      last_q <= 1'b0;
      pend_q <= 1'b0;
      have_q <= 1'b0;
    end else if (busy) begin
      if (done_now) busy <= 1'b0;
      if (beat && last && !mode_q.rd) last_q <= 1'b1;
      if (beat && !mode_q.rd) pend_q <= 1'b1;
      if (rsp_fire) begin
        have_q <= 1'b1;
        buf_q  <= mem_rsp_data;
      end
      if (tx_fire) begin
        have_q <= 1'b0;
        pend_q <= 1'b0;
      end
      held_q <= bnd_set || (held_q && !(cfg_wr && (cfg_sel == SEL_ADDR)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_done <= 1'b0;
      irq_bnd  <= 1'b0;
      stop_req <= 1'b0;
    end else begin
      irq_done <= done_now || (irq_done && !(sts_clr && cfg_wdata[STS_DONE]));
      irq_bnd  <= bnd_set  || (irq_bnd  && !(sts_clr && cfg_wdata[STS_BND]));
      stop_req <= done_now && mode_q.multi && mode_q.astop;
    end
  end
endmodule

// File: rtl/sd_sdma_checker.sv
module sd_sdma_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [2:0]        cfg_sel,
  input logic [ADDR_W-1:0] sys_addr,
  input logic              busy,
  input logic              irq_done,
  input logic              irq_bnd,
  input logic              stop_req,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              card_rx_ready,
  input logic              card_tx_valid,
  input logic              card_tx_ready,
  input logic [DATA_W-1:0] card_tx_data
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !card_rx_ready);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !(cfg_wr && cfg_sel == 3'd0))
      |=> sys_addr == $past(sys_addr) + ADDR_W'(1));

  p_bnd_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_bnd) |-> $past(mem_req_valid && mem_req_ready));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !busy);

  p_stop_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !busy && $past(busy));

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (card_tx_valid && !card_tx_ready) |=> card_tx_valid && $stable(card_tx_data));
endmodule

bind sd_sdma_engine sd_sdma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .sys_addr(sys_addr), .busy(busy), .irq_done(irq_done), .irq_bnd(irq_bnd),
  .stop_req(stop_req), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .card_rx_ready(card_rx_ready),
  .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
  .card_tx_data(card_tx_data)
);

// File: tb/sd_sdma_engine_tb.sv
module sd_sdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] sys_addr;
  logic        busy, irq_done, irq_bnd, stop_req;
  logic        card_rx_valid = 1'b0;
  logic [7:0]  card_rx_data = '0;
  logic        card_rx_ready;
  logic        card_tx_valid;
  logic [7:0]  card_tx_data;
  logic        card_tx_ready = 1'b0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        mem_rsp_ready;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sd_sdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sys_addr(sys_addr), .busy(busy),
    .irq_done(irq_done), .irq_bnd(irq_bnd), .stop_req(stop_req),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_ready(mem_rsp_ready)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] src_byte(input int k, input logic [7:0] salt);
    return 8'(k * 37) ^ salt;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_set(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_xfer(input bit rd, input logic [31:0] start, input int len,
                          input int cnt, input int code, input bit multi,
                          input bit astop);
    int total, exp_p, pauses, beats, src_idx, tx_idx, stops, cyc;
    int data_bad, addr_bad, held_bad, stab_bad, bphase, hold_cnt, rsp_wait;
    bit rx_v, rsp_pend, tx_wait, finished;
    logic [31:0] rsp_addr;
    logic [7:0] tx_prev, salt;
    longint size;
    total = multi ? len * cnt : len;
    size = longint'(4096) << code;
    exp_p = 0;
    for (int k = 1; k < total; k++)
      if (((longint'(start) + k) % size) == 0) exp_p++;
    pauses = 0; beats = 0; src_idx = 0; tx_idx = 0; stops = 0; cyc = 0;
    data_bad = 0; addr_bad = 0; held_bad = 0; stab_bad = 0; bphase = 0;
    hold_cnt = 0; rsp_wait = 0; rx_v = 0; rsp_pend = 0; tx_wait = 0;
    finished = 0; rsp_addr = '0; tx_prev = '0; salt = 8'($urandom);
    cfg_set(3'd0, start);
    cfg_set(3'd1, (32'(code) << 12) | 32'(len));
    cfg_set(3'd2, 32'(cnt));
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 3'd3;
    cfg_wdata = 32'h3 | (32'(astop) << 2) | (32'(rd) << 4) | (32'(multi) << 5);
    while (!finished && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (stop_req) stops++;
      if (tx_wait && !(card_tx_valid && card_tx_data == tx_prev)) stab_bad++;
      if (irq_done) begin
        finished = 1;
        break;
      end
      cfg_wr = 1'b0;
      if (irq_bnd) begin
        if (bphase == 0) begin
          pauses++;
          if (sys_addr != start + 32'(beats)) addr_bad++;
          bphase = 1;
          hold_cnt = int'($urandom % 5);
        end
        if (bphase == 1) begin
          if (hold_cnt == 0) begin
            cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_wdata = sys_addr; bphase = 2;
          end else hold_cnt--;
        end else if (bphase == 2) begin
          cfg_wr = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h8; bphase = 3;
        end
      end else bphase = 0;
      if (rd && !rx_v && src_idx < total && ($urandom % 4) != 0) rx_v = 1;
      card_rx_valid = rx_v;
      card_rx_data = src_byte(src_idx, salt);
      mem_req_ready = ($urandom % 4) != 0;
      card_tx_ready = ($urandom % 3) != 0;
      if (rsp_pend && rsp_wait == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem_byte(rsp_addr);
      end else begin
        mem_rsp_valid = 1'b0;
        if (rsp_pend) rsp_wait--;
      end
      #1;
      if (bphase == 1 && mem_req_valid) held_bad++;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_addr != start + 32'(beats)) addr_bad++;
        if (mem_req_we != rd) data_bad++;
        if (rd) begin
          if (mem_req_wdata != src_byte(beats, salt)) data_bad++;
        end else begin
          rsp_pend = 1; rsp_addr = mem_req_addr; rsp_wait = int'($urandom % 3);
        end
        beats++;
      end
      if (card_rx_valid && card_rx_ready) begin
        src_idx++; rx_v = 0;
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_pend = 0;
      if (card_tx_valid && card_tx_ready) begin
        if (card_tx_data != mem_byte(start + 32'(tx_idx))) data_bad++;
        tx_idx++; tx_wait = 0;
      end else tx_wait = card_tx_valid;
      tx_prev = card_tx_data;
    end
    cfg_wr = 1'b0; card_rx_valid = 1'b0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0; card_tx_ready = 1'b0;
    check(finished == 1, "R8", "transfer completed", finished, 1);
    check(!busy, "R8", "busy low at completion", busy, 0);
    check(beats == total, "R5", "memory beats", beats, total);
    if (rd) check(data_bad == 0, "R3", "write-beat data/address errors", data_bad, 0);
    else check(data_bad == 0 && tx_idx == total, "R4", "card bytes delivered", tx_idx, total);
    check(addr_bad == 0, "R7", "beat/pause address errors", addr_bad, 0);
    check(sys_addr == start + 32'(total), "R7", "final sys_addr", sys_addr, start + 32'(total));
    check(pauses == exp_p, "R6", "boundary pauses", pauses, exp_p);
    check(held_bad == 0, "R6", "requests during pause", held_bad, 0);
    check(stab_bad == 0, "R11", "card tx hold violations", stab_bad, 0);
    @(negedge clk);
    check(stop_req == 1'b0, "R10", "stop pulse one cycle", stop_req, 0);
    check(stops == int'(multi && astop), "R10", "stop pulses", stops, int'(multi && astop));
    cfg_set(3'd5, 32'hFFFF_FFF5);
    check(irq_done == 1'b1, "R9", "done kept by write with bit1 clear", irq_done, 1);
    cfg_set(3'd5, 32'h2);
    check(irq_done == 1'b0, "R9", "done cleared by bit1", irq_done, 0);
  endtask

  task automatic try_bad(input logic [2:0] sel, input logic [31:0] data,
                         input string why);
    cfg_set(sel, data);
    check(!busy && !mem_req_valid, "R2", why, busy, 0);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !irq_done && !irq_bnd && !stop_req && sys_addr == 0 &&
          !mem_req_valid && !card_tx_valid, "R1", "reset state", busy, 0);

    run_xfer(1, 32'h100, 16, 5, 0, 0, 0);
    run_xfer(0, 32'h0FF8, 8, 3, 0, 1, 1);
    run_xfer(1, 32'h0FF0, 16, 1, 0, 0, 0);
    run_xfer(1, 32'h0FFE, 8, 1, 1, 0, 0);
    run_xfer(0, 32'h1FFE, 8, 1, 1, 0, 0);
    run_xfer(0, 32'h7FFFC, 8, 1, 7, 0, 0);
    run_xfer(1, 32'h40, 6, 0, 0, 0, 1);
    run_xfer(1, 32'h0FF8, 512, 9, 0, 1, 0);

    for (int i = 0; i < 10; i++) begin
      logic [31:0] st;
      st = 32'(($urandom % 64) * 4096 + 4096) - 32'($urandom % 20);
      run_xfer(1'($urandom), st, 1 + int'($urandom % 40), 1 + int'($urandom % 4),
               int'($urandom % 8), 1'($urandom), 1'($urandom));
    end

    cfg_set(3'd1, 32'd4);
    cfg_set(3'd2, 32'd2);
    try_bad(3'd3, 32'h12, "DMA enable clear");
    cfg_set(3'd4, 32'h10);
    try_bad(3'd3, 32'h13, "non single-address host mode");
    cfg_set(3'd4, 32'h0);
    try_bad(3'd3, 32'h21, "multi without count enable");
    cfg_set(3'd2, 32'd0);
    try_bad(3'd3, 32'h23, "multi with zero count");
    cfg_set(3'd1, 32'd0);
    try_bad(3'd3, 32'h01, "zero block length");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule